// File: doc/BRIEF.md
# Four-Lane Byte Buffer with Word and Byte Access

This block holds the transmit and receive data of a serial flash controller. Each direction is four byte-wide FIFOs of 16 entries, called lanes. A 32-bit access moves one byte in every lane at once, so a direction holds up to 64 bytes when it is filled by words. A byte access touches one lane only, so a lane that is filled by bytes alone holds 16 entries. A write pointer and a read pointer step through the lanes. Word and byte traffic can therefore be mixed in one direction and the bytes still come out in the order they went in. Bits 7:0 of a word are always the oldest byte.

On the transmit side the bus writes words or bytes, and the serializer takes one byte per handshake. On the receive side the deserializer pushes one byte per handshake, and the bus reads words or bytes. Both byte streams use valid/ready handshakes. `ser_valid` is high whenever a transmit byte is held. A byte leaves only in a cycle where `ser_valid` and `ser_ready` are both high, and `ser_data` holds its value while `ser_ready` is low. `des_ready` is low while the receive side is full. A byte enters only in a cycle where `des_valid` and `des_ready` are both high.

The status flags are sticky. Each flag is loaded from its live condition on every clock. A flag drops only when a 1 is written to its clear bit and its condition no longer holds. Software can therefore clear a flag and read it again to see the live state. Bus accesses are single-cycle pulses. Read data is combinational and is valid in the cycle of the read pulse.

Top module: `quad_lane_buffer`

## Requirements
- R1: The serializer receives transmit bytes in the order they were written. A word write contributes its four bytes starting with bits 7:0 and ending with bits 31:24. A byte write contributes `tx_wdata[7:0]`.
- R2: `ser_valid` is high exactly when at least one transmit byte is held. A byte is removed only in a cycle where `ser_valid` and `ser_ready` are both high. While `ser_valid` is high and `ser_ready` is low, `ser_data` holds its value.
- R3: `des_ready` is low exactly when the receive side holds 64 bytes. A byte is stored only in a cycle where `des_valid` and `des_ready` are both high.
- R4: A receive word read returns the four oldest bytes in the same cycle, with the oldest in bits 7:0, and removes them. A receive byte read returns the oldest byte in bits 7:0 with zero in bits 31:8, and removes it.
- R5: A transmit word write is refused while more than 60 bytes are held, which is when some lane is full. A transmit byte write is refused only when 64 bytes are held. A refused write stores nothing.
- R6: A receive word read is refused when fewer than 4 bytes are held. A receive byte read is refused when no byte is held. A refused read returns zero and removes nothing.
- R7: Status bit 10 (illegal) is set by any refused access. It is also set when a word access and a byte access are made in the same direction in the same cycle. Such a pair is ignored, and a read pair returns zero.
- R8: The transmit status bits are: bit 0 word-full (more than 60 bytes), bit 1 byte-full (64 bytes), bit 2 half (at least 32 bytes), bit 3 empty (0 bytes), bit 4 trigger (at most 16 bytes).
- R9: The receive status bits are: bit 5 full (64 bytes), bit 6 half (at least 32 bytes), bit 7 trigger (at least 16 bytes), bit 8 word-available (at least 4 bytes), bit 9 byte-available (at least 1 byte).
- R10: At each clock, every status bit that was 1 and whose `stat_clr` bit is 0 stays 1. Every status bit whose condition held before that edge becomes 1. A bit that is cleared while its condition still holds therefore stays 1.
- R11: `soft_clr` empties both directions, resets the lane pointers and clears all status bits at the next clock edge. Every access and handshake in that cycle is ignored, and a read in that cycle returns zero.
- R12: During reset `stat` is 0, `ser_valid` is 0, `des_ready` is 1 and `rx_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of both directions and of the status |
| tx_wr_word | input | 1 | Transmit word write pulse |
| tx_wr_byte | input | 1 | Transmit byte write pulse |
| tx_wdata | input | 32 | Transmit write data |
| ser_valid | output | 1 | Transmit byte available to the serializer |
| ser_ready | input | 1 | Serializer accepts the byte |
| ser_data | output | 8 | Oldest transmit byte |
| des_valid | input | 1 | Deserializer offers a byte |
| des_ready | output | 1 | Receive side can accept a byte |
| des_data | input | 8 | Received byte |
| rx_rd_word | input | 1 | Receive word read pulse |
| rx_rd_byte | input | 1 | Receive byte read pulse |
| rx_rdata | output | 32 | Receive read data, valid in the cycle of the read pulse |
| stat_clr | input | 11 | Write 1 to clear a status bit |
| stat | output | 11 | Sticky status flags |

## Verification
The assertions check properties that must hold on every cycle:
- `ser_data` holds its value under back-pressure.
- `des_ready` stays low while the receive side is full and nothing reads it.
- A byte read carries zero in its upper bits, and a word-plus-byte read pair returns zero and sets the illegal flag.
- Status bits are never lost unless they are cleared.
- A soft clear leaves the block empty with its status cleared.

Byte order across mixed word and byte traffic can only be shown by the bench's scenarios, where the lane pointers have rotated away from lane 0. The same holds for the thresholds at 4, 16, 32, 60 and 64 bytes and for flags that come back at once after a clear.

// File: rtl/lane_buf_pkg.sv
package lane_buf_pkg;
  localparam int unsigned NSTAT        = 11;
  localparam int unsigned ST_TX_WFULL  = 0;
  localparam int unsigned ST_TX_BFULL  = 1;
  localparam int unsigned ST_TX_HALF   = 2;
  localparam int unsigned ST_TX_EMPTY  = 3;
  localparam int unsigned ST_TX_TRIG   = 4;
  localparam int unsigned ST_RX_FULL   = 5;
  localparam int unsigned ST_RX_HALF   = 6;
  localparam int unsigned ST_RX_TRIG   = 7;
  localparam int unsigned ST_RX_WAVAIL = 8;
  localparam int unsigned ST_RX_BAVAIL = 9;
  localparam int unsigned ST_ILLEGAL   = 10;
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rp];
endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
  parameter int LANES = 4,
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int DW   = LANES * W,
  localparam int PW   = $clog2(LANES),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(LANES * DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_word,
  input  logic          push_byte,
  input  logic [DW-1:0] push_data,
  input  logic          pop_word,
  input  logic          pop_byte,
  output logic [DW-1:0] pop_data,
  output logic          can_push_word,
  output logic          can_push_byte,
  output logic          can_pop_word,
  output logic          can_pop_byte,
  output logic [TW-1:0] total
);
  logic [PW-1:0]    wp, rp;
  logic [W-1:0]     l_din  [LANES];
  logic [W-1:0]     l_head [LANES];
  logic [CW-1:0]    l_cnt  [LANES];
  logic [LANES-1:0] l_push, l_pop, l_full, l_empty;
  logic [TW-1:0]    add_n, sub_n;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [PW-1:0] woff;
    assign woff      = PW'(i) - wp;
    assign l_push[i] = push_word | (push_byte & (wp == PW'(i)));
    assign l_pop[i]  = pop_word  | (pop_byte  & (rp == PW'(i)));
    assign l_din[i]  = push_word ? push_data[woff*W +: W] : push_data[W-1:0];

    lane_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push(l_push[i]), .din(l_din[i]), .pop(l_pop[i]),
      .head(l_head[i]), .count(l_cnt[i])
    );

    assign l_full[i]  = (l_cnt[i] == CW'(DEPTH));
    assign l_empty[i] = (l_cnt[i] == '0);
    assign pop_data[i*W +: W] = l_head[PW'(i) + rp];
  end

  assign can_push_word = ~|l_full;
  assign can_push_byte = ~l_full[wp];
  assign can_pop_word  = ~|l_empty;
  assign can_pop_byte  = ~l_empty[rp];

  assign add_n = push_word ? TW'(LANES) : TW'(push_byte);
  assign sub_n = pop_word  ? TW'(LANES) : TW'(pop_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; total <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; total <= '0;
    end else begin
      if (push_byte) wp <= wp + 1'b1;
      if (pop_byte)  rp <= rp + 1'b1;
      total <= total + add_n - sub_n;
    end
  end
endmodule

// File: rtl/sticky_status.sv
module sticky_status #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] live,
  output logic [N-1:0] stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat <= '0;
    else if (clr_all) stat <= '0;
    else              stat <= (stat & ~clr_bits) | live;
  end
endmodule

// File: rtl/quad_lane_buffer.sv
module quad_lane_buffer
  import lane_buf_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int W       = 8,
  parameter int DEPTH   = 16,
  parameter int TX_TRIG = 16,
  parameter int RX_TRIG = 16,
  localparam int DW     = LANES * W,
  localparam int TW     = $clog2(LANES * DEPTH + 1),
  localparam int CAP    = LANES * DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             tx_wr_word,
  input  logic             tx_wr_byte,
  input  logic [DW-1:0]    tx_wdata,
  output logic             ser_valid,
  input  logic             ser_ready,
  output logic [W-1:0]     ser_data,
  input  logic             des_valid,
  output logic             des_ready,
  input  logic [W-1:0]     des_data,
  input  logic             rx_rd_word,
  input  logic             rx_rd_byte,
  output logic [DW-1:0]    rx_rdata,
  input  logic [NSTAT-1:0] stat_clr,
  output logic [NSTAT-1:0] stat
);
  logic          tx_cpw, tx_cpb, tx_cqw, tx_cqb, tx_pw, tx_pb, tx_pop;
  logic [DW-1:0] tx_head;
  logic [TW-1:0] tx_total;
  logic          rx_cpw, rx_cpb, rx_cqw, rx_cqb, rx_pw, rx_pb, rx_push;
  logic [DW-1:0] rx_head;
  logic [TW-1:0] rx_total;
  logic          bad_tx, bad_rx;
  logic [NSTAT-1:0] live;
  logic          unused_ok;

  assign tx_pw  = tx_wr_word & ~tx_wr_byte & tx_cpw;
  assign tx_pb  = tx_wr_byte & ~tx_wr_word & tx_cpb;
  assign tx_pop = ser_valid & ser_ready;

  lane_bank #(.LANES(LANES), .W(W), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr),
    .push_word(tx_pw), .push_byte(tx_pb), .push_data(tx_wdata),
    .pop_word(1'b0), .pop_byte(tx_pop), .pop_data(tx_head),
    .can_push_word(tx_cpw), .can_push_byte(tx_cpb),
    .can_pop_word(tx_cqw), .can_pop_byte(tx_cqb), .total(tx_total)
  );

  assign ser_valid = tx_cqb;
  assign ser_data  = tx_head[W-1:0];

  assign des_ready = rx_cpb;
  assign rx_push   = des_valid & des_ready;
  assign rx_pw     = rx_rd_word & ~rx_rd_byte & rx_cqw & ~soft_clr;
  assign rx_pb     = rx_rd_byte & ~rx_rd_word & rx_cqb & ~soft_clr;

  lane_bank #(.LANES(LANES), .W(W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr),
    .push_word(1'b0), .push_byte(rx_push), .push_data({{(DW-W){1'b0}}, des_data}),
    .pop_word(rx_pw), .pop_byte(rx_pb), .pop_data(rx_head),
    .can_push_word(rx_cpw), .can_push_byte(rx_cpb),
    .can_pop_word(rx_cqw), .can_pop_byte(rx_cqb), .total(rx_total)
  );

  always_comb begin
    if (rx_pw)      rx_rdata = rx_head;
    else if (rx_pb) rx_rdata = {{(DW-W){1'b0}}, rx_head[W-1:0]};
    else            rx_rdata = '0;
  end

  assign bad_tx = (tx_wr_word & tx_wr_byte) | (tx_wr_word & ~tx_wr_byte & ~tx_cpw)
                | (tx_wr_byte & ~tx_wr_word & ~tx_cpb);
  assign bad_rx = (rx_rd_word & rx_rd_byte) | (rx_rd_word & ~rx_rd_byte & ~rx_cqw)
                | (rx_rd_byte & ~rx_rd_word & ~rx_cqb);

  always_comb begin
    live               = '0;
    live[ST_TX_WFULL]  = ~tx_cpw;
    live[ST_TX_BFULL]  = ~tx_cpb;
    live[ST_TX_HALF]   = tx_total >= TW'(CAP / 2);
    live[ST_TX_EMPTY]  = tx_total == '0;
    live[ST_TX_TRIG]   = tx_total <= TW'(TX_TRIG);
    live[ST_RX_FULL]   = rx_total == TW'(CAP);
    live[ST_RX_HALF]   = rx_total >= TW'(CAP / 2);
    live[ST_RX_TRIG]   = rx_total >= TW'(RX_TRIG);
    live[ST_RX_WAVAIL] = rx_cqw;
    live[ST_RX_BAVAIL] = rx_cqb;
    live[ST_ILLEGAL]   = bad_tx | bad_rx;
  end

  sticky_status #(.N(NSTAT)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr_all(soft_clr),
    .clr_bits(stat_clr), .live(live), .stat(stat)
  );

  assign unused_ok = ^{tx_head[DW-1:W], tx_cqw, rx_cpw};
endmodule

// File: rtl/lane_buffer_chk.sv
module lane_buffer_chk
  import lane_buf_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_clr,
  input logic             ser_valid,
  input logic             ser_ready,
  input logic [W-1:0]     ser_data,
  input logic             des_ready,
  input logic             rx_rd_word,
  input logic             rx_rd_byte,
  input logic [DW-1:0]    rx_rdata,
  input logic [NSTAT-1:0] stat_clr,
  input logic [NSTAT-1:0] stat
);
  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !ser_ready && !soft_clr) |=> (ser_valid && $stable(ser_data))); // R2

  AST_DES_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!des_ready && !rx_rd_word && !rx_rd_byte && !soft_clr) |=> !des_ready); // R3

  AST_BYTE_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_byte && !rx_rd_word) |-> (rx_rdata[DW-1:W] == '0)); // R4

  AST_PAIR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_word && rx_rd_byte) |-> (rx_rdata == '0)); // R7

  AST_PAIR_READ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_word && rx_rd_byte && !soft_clr) |=> stat[ST_ILLEGAL]); // R7

  AST_NO_LOST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr |=> ((($past(stat) & ~$past(stat_clr)) & ~stat) == '0)); // R10

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!ser_valid && des_ready && stat == '0)); // R11
endmodule

bind quad_lane_buffer lane_buffer_chk #(.W(W), .DW(DW)) chk_i (.*);

// File: tb/quad_lane_buffer_tb_top.sv
module quad_lane_buffer_tb_top;
  localparam int CYC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_clr = 0, tx_wr_word = 0, tx_wr_byte = 0, ser_ready = 0;
  logic des_valid = 0, rx_rd_word = 0, rx_rd_byte = 0;
  logic [31:0] tx_wdata = '0;
  logic [7:0]  des_data = '0;
  logic [10:0] stat_clr = '0;
  logic        ser_valid, des_ready;
  logic [7:0]  ser_data;
  logic [31:0] rx_rdata;
  logic [10:0] stat;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] tq[$];
  logic [7:0] rq[$];
  logic [10:0] m_stat = '0;

  always #(CYC/2) clk = ~clk;

  quad_lane_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .tx_wr_word(tx_wr_word), .tx_wr_byte(tx_wr_byte), .tx_wdata(tx_wdata),
    .ser_valid(ser_valid), .ser_ready(ser_ready), .ser_data(ser_data),
    .des_valid(des_valid), .des_ready(des_ready), .des_data(des_data),
    .rx_rd_word(rx_rd_word), .rx_rd_byte(rx_rd_byte), .rx_rdata(rx_rdata),
    .stat_clr(stat_clr), .stat(stat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string bit_tag(int b);
    if (b <= 4) return "R8 tx status";
    if (b <= 9) return "R9 rx status";
    return "R7 illegal";
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (soft_clr) return 32'h0;
    if (rx_rd_word && !rx_rd_byte && rq.size() >= 4) return {rq[3], rq[2], rq[1], rq[0]};
    if (rx_rd_byte && !rx_rd_word && rq.size() >= 1) return {24'h0, rq[0]};
    return 32'h0;
  endfunction

  task automatic compare();
    bit ev;
    ev = tq.size() > 0;
    chk(ser_valid === ev, "R2 ser_valid", 32'(ser_valid), 32'(ev));
    if (ev) chk(ser_data === tq[0], "R1 ser_data order", 32'(ser_data), 32'(tq[0]));
    chk(des_ready === (rq.size() < 64), "R3 des_ready", 32'(des_ready), 32'(rq.size() < 64));
    chk(rx_rdata === exp_rdata(), "R4 rx_rdata", rx_rdata, exp_rdata());
    for (int b = 0; b < 11; b++)
      chk(stat[b] === m_stat[b], bit_tag(b), 32'(stat[b]), 32'(m_stat[b]));
  endtask

  task automatic model_update();
    int ts, rs;
    logic [10:0] lv;
    bit ill;
    ts = tq.size(); rs = rq.size();
    ill = (tx_wr_word && tx_wr_byte) || (tx_wr_word && !tx_wr_byte && ts > 60)
       || (tx_wr_byte && !tx_wr_word && ts == 64) || (rx_rd_word && rx_rd_byte)
       || (rx_rd_word && !rx_rd_byte && rs < 4) || (rx_rd_byte && !rx_rd_word && rs == 0);
    lv = '0;
    lv[0] = ts > 60; lv[1] = ts == 64; lv[2] = ts >= 32; lv[3] = ts == 0; lv[4] = ts <= 16;
    lv[5] = rs == 64; lv[6] = rs >= 32; lv[7] = rs >= 16; lv[8] = rs >= 4; lv[9] = rs >= 1;
    lv[10] = ill;
    if (soft_clr) begin
      tq.delete(); rq.delete(); m_stat = '0;
    end else begin
      m_stat = (m_stat & ~stat_clr) | lv;
      if (ts > 0 && ser_ready) void'(tq.pop_front());
      if (tx_wr_word && !tx_wr_byte && ts <= 60)
        for (int k = 0; k < 4; k++) tq.push_back(tx_wdata[k*8 +: 8]);
      if (tx_wr_byte && !tx_wr_word && ts < 64) tq.push_back(tx_wdata[7:0]);
      if (rx_rd_word && !rx_rd_byte && rs >= 4) repeat (4) void'(rq.pop_front());
      if (rx_rd_byte && !rx_rd_word && rs >= 1) void'(rq.pop_front());
      if (des_valid && rs < 64) rq.push_back(des_data);
    end
  endtask

  task automatic step();
    #5;
    compare();
    model_update();
    @(negedge clk);
  endtask

  task automatic wr_word(input logic [31:0] d);
    tx_wr_word = 1; tx_wdata = d; step(); tx_wr_word = 0;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    tx_wr_byte = 1; tx_wdata = {24'h0, d}; step(); tx_wr_byte = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(stat === 11'h0, "R12 stat in reset", 32'(stat), 0);
    chk(ser_valid === 1'b0, "R12 ser_valid in reset", 32'(ser_valid), 0);
    chk(des_ready === 1'b1, "R12 des_ready in reset", 32'(des_ready), 1);
    chk(rx_rdata === 32'h0, "R12 rx_rdata in reset", rx_rdata, 0);
    rst_n = 1;
    repeat (3) step();
    chk(stat === 11'h018, "R8 empty and trigger after reset", 32'(stat), 32'h18);

    // R1: word and byte order
    ser_ready = 0;
    wr_word(32'h44332211); wr_word(32'h88776655); wr_byte(8'h99); wr_word(32'hDDCCBBAA);
    chk(ser_data === 8'h11, "R1 first byte is bits 7:0", 32'(ser_data), 32'h11);
    ser_ready = 1;
    repeat (15) step();

    // R2: back-pressure while draining, lanes rotated
    ser_ready = 0;
    wr_byte(8'h5A); wr_word(32'h0D0C0B0A); wr_word(32'h1D1C1B1A);
    for (int k = 0; k < 24; k++) begin
      ser_ready = k[0];
      step();
    end
    ser_ready = 0;

    // R5: capacity limits
    wr_byte(8'h01);
    for (int k = 0; k < 15; k++) wr_word(32'h10203040 + 32'(k));
    wr_word(32'hDEADBEEF);
    chk(stat[0] === 1'b1, "R5 word full above 60 bytes", 32'(stat[0]), 1);
    chk(stat[10] === 1'b1, "R7 refused word write flags", 32'(stat[10]), 1);
    stat_clr = '1; step(); stat_clr = '0;
    repeat (3) wr_byte(8'hB7);
    wr_byte(8'hEE);
    chk(stat[1] === 1'b1, "R5 byte full at 64 bytes", 32'(stat[1]), 1);
    chk(stat[10] === 1'b1, "R7 refused byte write flags", 32'(stat[10]), 1);
    ser_ready = 1;
    repeat (68) step();
    ser_ready = 0;

    // R10: sticky then cleared
    chk(stat[0] === 1'b1, "R10 word full stays sticky", 32'(stat[0]), 1);
    stat_clr = '1; step(); stat_clr = '0;
    chk(stat[0] === 1'b0, "R10 cleared flag drops", 32'(stat[0]), 0);
    chk(stat[3] === 1'b1, "R10 live empty re-asserts", 32'(stat[3]), 1);

    // R3: fill receive side past capacity
    des_valid = 1;
    for (int k = 0; k < 70; k++) begin
      des_data = 8'(k);
      step();
    end
    chk(des_ready === 1'b0, "R3 full receive side blocks", 32'(des_ready), 0);
    chk(stat[5] === 1'b1, "R9 rx full flag", 32'(stat[5]), 1);
    des_valid = 0;
    rx_rd_byte = 1; #1;
    chk(rx_rdata === 32'h0, "R4 byte read oldest", rx_rdata, 0);
    step(); rx_rd_byte = 0;
    rx_rd_word = 1;
    repeat (15) step();
    #1;
    chk(rx_rdata === 32'h0, "R6 word read with 3 bytes is zero", rx_rdata, 0);
    step(); rx_rd_word = 0;
    chk(stat[10] === 1'b1, "R6 refused word read flags", 32'(stat[10]), 1);
    rx_rd_word = 1; rx_rd_byte = 1; #1;
    chk(rx_rdata === 32'h0, "R7 word plus byte read is zero", rx_rdata, 0);
    step(); rx_rd_word = 0;
    repeat (3) step();
    #1;
    chk(rx_rdata === 32'h0, "R6 byte read when empty is zero", rx_rdata, 0);
    step(); rx_rd_byte = 0;

    // R4: mixed traffic ordering
    for (int k = 0; k < 48; k++) begin
      des_valid  = (k % 3) != 0;
      des_data   = 8'h80 + 8'(k);
      rx_rd_byte = (k % 5) == 2;
      rx_rd_word = (k % 7) == 6;
      step();
    end
    des_valid = 0; rx_rd_byte = 0; rx_rd_word = 0;

    // R11: soft clear
    wr_word(32'hA1A2A3A4);
    des_valid = 1; des_data = 8'h3C; step(); step();
    soft_clr = 1; tx_wr_byte = 1; tx_wdata = 32'h77; rx_rd_byte = 1;
    step();
    soft_clr = 0; tx_wr_byte = 0; rx_rd_byte = 0; des_valid = 0;
    chk(ser_valid === 1'b0, "R11 tx empty after clear", 32'(ser_valid), 0);
    chk(des_ready === 1'b1, "R11 rx empty after clear", 32'(des_ready), 1);
    chk(stat === 11'h0, "R11 status cleared", 32'(stat), 0);
    step();
    wr_byte(8'hC1); wr_word(32'h04030201);
    ser_ready = 1;
    repeat (7) step();

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule